// File: doc/BRIEF.md
# Configurable Output Macrocell for a Programmable Sum-of-Products Array

This block is one output cell of a programmable AND/OR logic device. The product-term generator sits upstream and hands the cell eight product terms: seven main terms plus one auxiliary term. The cell turns them into a pin drive value, a pin output enable and a feedback bit that goes back into the AND array. The tri-state pad is outside the block. It is driven by `pin_out` and `pin_oe`, and it returns the level seen on the pin through `pin_in`.

Four configuration bits set the cell's behaviour: two global mode bits shared across the device, and two local bits. The local bits pick the output polarity and whether the cell is registered or combinational. Together these bits choose:

- how many terms feed the OR gate,
- whether the output passes through a D flip-flop clocked by the shared clock pin,
- where the output enable comes from: a constant, the auxiliary term, or the shared active-low enable pin,
- whether feedback is taken from the register or from the pin.

The flip-flop is cleared by the power-on reset. A registered output therefore shows the inactive level before the first clock.

Top module: `pal_macrocell`

## Requirements
- R1: Encoding: `gmode[0]` is the first global bit and `gmode[1]` the second. Simple mode is `gmode=2'b01`. In simple mode with `reg_sel=0`, the cell ORs all eight terms, holds `pin_oe=1`, drives `pin_out` with the OR when `inv_sel=1` and with its complement when `inv_sel=0`, and sets `fb` equal to `pin_in`.
- R2: In simple mode with `reg_sel=1`, whatever `inv_sel` is, `pin_oe` is 0 and `fb` equals `pin_in`.
- R3: Complex mode is `gmode=2'b11` with `reg_sel=1`. Only terms 0 to 6 feed the OR, `pin_oe` equals term 7, `inv_sel` selects polarity as in R1, and `fb` equals `pin_in`.
- R4: Registered mode is `gmode=2'b10`. With `reg_sel=0`, the flip-flop captures the OR of all eight terms on each rising edge of `clk`. `pin_out` is the flip-flop output when `inv_sel=1` and its complement when `inv_sel=0`. `pin_oe` equals `!oe_n`, and `fb` equals the flip-flop output.
- R5: In registered mode with `reg_sel=1`, the cell is combinational and behaves exactly as in R3.
- R6: While `rst_n` is low the flip-flop is held at 0. In registered mode with `reg_sel=0`, `pin_out` then reads 0 for `inv_sel=1` and 1 for `inv_sel=0`.
- R7: Unlisted codes force `pin_oe=0` and make `fb` equal `pin_in`. These are `gmode=2'b00` with either `reg_sel`, and `gmode=2'b11` with `reg_sel=0`.
- R8: In every configuration except registered mode with `reg_sel=0`, `pin_oe`, `pin_out` and `fb` do not depend on `oe_n` or on clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock pin, rising edge clocks the cell register |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pterm | input | 8 | Product terms; bits 0..6 main, bit 7 auxiliary |
| gmode | input | 2 | Global mode bits (01 simple, 11 complex, 10 registered) |
| inv_sel | input | 1 | Polarity: 1 active high, 0 active low |
| reg_sel | input | 1 | Local register/combinational select |
| oe_n | input | 1 | Shared active-low output-enable pin |
| pin_in | input | 1 | Level read back from the I/O pin |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Pad output enable |
| fb | output | 1 | Feedback into the AND array |

## Verification
The assertions treat the configuration bits as static between clock edges. They also rely on the product terms and `oe_n` changing only away from the rising edge of `clk`, so that the register captures a well-defined OR value. The register-capture property additionally requires that reset was released at the previous edge. The bench meets these conditions by changing every input on the falling edge and sampling one nanosecond later. It changes configuration only on falling edges, and it releases reset on a falling edge.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;

  localparam int unsigned NTERM = 8;

  typedef enum logic [1:0] {
    GM_NONE   = 2'b00,
    GM_SIMPLE = 2'b01,
    GM_REGD   = 2'b10,
    GM_CPLX   = 2'b11
  } gmode_e;

  typedef enum logic [2:0] {
    CFG_COMB_ON = 3'd0,  // all terms, always enabled
    CFG_INPUT   = 3'd1,  // buffer off, pin is an input
    CFG_COMB_PT = 3'd2,  // main terms, auxiliary term enables
    CFG_REGD    = 3'd3,  // registered, enable from pin
    CFG_OFF     = 3'd4   // unlisted code
  } cell_cfg_e;

  function automatic cell_cfg_e decode_cfg(input logic [1:0] gm, input logic rc);
    cell_cfg_e c;
    case (gm)
      GM_SIMPLE: c = rc ? CFG_INPUT : CFG_COMB_ON;
      GM_CPLX:   c = rc ? CFG_COMB_PT : CFG_OFF;
      GM_REGD:   c = rc ? CFG_COMB_PT : CFG_REGD;
      default:   c = CFG_OFF;
    endcase
    return c;
  endfunction

  function automatic logic apply_pol(input logic v, input logic active_high);
    return active_high ? v : ~v;
  endfunction

endpackage

// File: rtl/pal_cell_decode.sv
module pal_cell_decode
  import pal_cell_pkg::*;
(
  input  logic [1:0] gmode,
  input  logic       reg_sel,
  output cell_cfg_e  cfg,
  output logic       use_aux,
  output logic       fb_from_reg
);
  always_comb begin
    cfg         = decode_cfg(gmode, reg_sel);
    use_aux     = (cfg == CFG_COMB_PT);
    fb_from_reg = (cfg == CFG_REGD);
  end
endmodule

// File: rtl/pal_cell_sop.sv
module pal_cell_sop #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] pt,
  output logic         sum_all,
  output logic         sum_main
);
  localparam int unsigned NMAIN = N - 1;
  logic [N-1:0] chain;

  assign chain[0] = pt[0];
  for (genvar i = 1; i < N; i++) begin : g_or
    assign chain[i] = chain[i-1] | pt[i];
  end

  assign sum_main = chain[NMAIN-1];
  assign sum_all  = chain[N-1];
endmodule

// File: rtl/pal_cell_reg.sv
module pal_cell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_cell_pkg::*;
#(
  parameter int unsigned N = NTERM
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pterm,
  input  logic [1:0]   gmode,
  input  logic         inv_sel,
  input  logic         reg_sel,
  input  logic         oe_n,
  input  logic         pin_in,
  output logic         pin_out,
  output logic         pin_oe,
  output logic         fb
);
  localparam int unsigned AUX = N - 1;

  cell_cfg_e cfg;
  logic      use_aux;
  logic      fb_from_reg;
  logic      sum_all;
  logic      sum_main;
  logic      comb_sum;
  logic      reg_q;

  pal_cell_decode u_dec (
    .gmode       (gmode),
    .reg_sel     (reg_sel),
    .cfg         (cfg),
    .use_aux     (use_aux),
    .fb_from_reg (fb_from_reg)
  );

  pal_cell_sop #(.N(N)) u_sop (
    .pt       (pterm),
    .sum_all  (sum_all),
    .sum_main (sum_main)
  );

  pal_cell_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sum_all),
    .q     (reg_q)
  );

  assign comb_sum = use_aux ? sum_main : sum_all;

  always_comb begin
    pin_out = apply_pol(fb_from_reg ? reg_q : comb_sum, inv_sel);
    fb      = fb_from_reg ? reg_q : pin_in;
    case (cfg)
      CFG_COMB_ON: pin_oe = 1'b1;
      CFG_COMB_PT: pin_oe = pterm[AUX];
      CFG_REGD:    pin_oe = ~oe_n;
      default:     pin_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] pterm,
  input logic [1:0] gmode,
  input logic       reg_sel,
  input logic       oe_n,
  input logic       pin_in,
  input logic       pin_oe,
  input logic       fb,
  input logic       sum_all,
  input logic       reg_q
);
  logic simple_on, simple_in, pt_oe, regd, unlisted;
  assign simple_on = (gmode == 2'b01) && !reg_sel;
  assign simple_in = (gmode == 2'b01) && reg_sel;
  assign pt_oe     = gmode[1] && reg_sel;
  assign regd      = (gmode == 2'b10) && !reg_sel;
  assign unlisted  = (gmode == 2'b00) || ((gmode == 2'b11) && !reg_sel);

  p_simple_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    simple_on |-> (pin_oe && fb == pin_in));
  p_input_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    simple_in |-> (!pin_oe && fb == pin_in));
  p_term_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pt_oe |-> (pin_oe == pterm[7] && fb == pin_in));
  p_reg_oe_fb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    regd |-> (pin_oe == !oe_n && fb == reg_q));
  p_reg_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> reg_q == $past(sum_all));
  p_reset_clear_r6: assert property (@(posedge clk)
    !rst_n |-> !reg_q);
  p_unlisted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unlisted |-> (!pin_oe && fb == pin_in));
endmodule

bind pal_macrocell pal_macrocell_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pterm   (pterm),
  .gmode   (gmode),
  .reg_sel (reg_sel),
  .oe_n    (oe_n),
  .pin_in  (pin_in),
  .pin_oe  (pin_oe),
  .fb      (fb),
  .sum_all (sum_all),
  .reg_q   (reg_q)
);

// File: tb/pal_macrocell_test.sv
`timescale 1ns/1ps
module pal_macrocell_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pterm = '0;
  logic [1:0] gmode = 2'b10;
  logic       inv_sel = 1'b1;
  logic       reg_sel = 1'b0;
  logic       oe_n = 1'b0;
  logic       pin_in = 1'b0;
  logic       pin_out, pin_oe, fb;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pal_macrocell uut (
    .clk(clk), .rst_n(rst_n), .pterm(pterm), .gmode(gmode),
    .inv_sel(inv_sel), .reg_sel(reg_sel), .oe_n(oe_n), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic pol(input logic v, input logic hi);
    return hi ? v : !v;
  endfunction

  task automatic setup(input logic [1:0] gm, input logic rc, input logic op);
    @(negedge clk);
    gmode = gm; reg_sel = rc; inv_sel = op;
  endtask

  task automatic drive_rand();
    @(negedge clk);
    pterm = 8'($urandom); oe_n = 1'($urandom); pin_in = 1'($urandom);
    #1;
  endtask

  task automatic t_reset();
    inv_sel = 1'b1; pterm = 8'hFF; #1;
    chk("R6", "pin_out active-high in reset", pin_out, 1'b0);
    chk("R4", "pin_oe follows oe_n", pin_oe, 1'b1);
    @(negedge clk); inv_sel = 1'b0; #1;
    chk("R6", "pin_out active-low in reset", pin_out, 1'b1);
    chk("R6", "fb in reset", fb, 1'b0);
    @(negedge clk); rst_n = 1'b1; pterm = '0;
  endtask

  task automatic t_simple_comb();
    for (int op = 0; op < 2; op++) begin
      setup(2'b01, 1'b0, 1'(op));
      for (int i = 0; i < 20; i++) begin
        drive_rand();
        if (i == 0) begin pterm = 8'h80; #1; end
        chk("R1", "pin_out", pin_out, pol(|pterm, 1'(op)));
        chk("R1", "pin_oe", pin_oe, 1'b1);
        chk("R1", "fb", fb, pin_in);
      end
    end
  endtask

  task automatic t_simple_input();
    for (int op = 0; op < 2; op++) begin
      setup(2'b01, 1'b1, 1'(op));
      for (int i = 0; i < 10; i++) begin
        drive_rand();
        chk("R2", "pin_oe", pin_oe, 1'b0);
        chk("R2", "fb", fb, pin_in);
      end
    end
  endtask

  task automatic t_term_oe(input logic [1:0] gm, input string req);
    for (int op = 0; op < 2; op++) begin
      setup(gm, 1'b1, 1'(op));
      for (int i = 0; i < 20; i++) begin
        drive_rand();
        if (i == 0) begin pterm = 8'h80; #1; end
        if (i == 1) begin pterm = 8'h40; #1; end
        chk(req, "pin_out", pin_out, pol(|pterm[6:0], 1'(op)));
        chk(req, "pin_oe", pin_oe, pterm[7]);
        chk(req, "fb", fb, pin_in);
      end
    end
  endtask

  task automatic t_registered();
    for (int op = 0; op < 2; op++) begin
      setup(2'b10, 1'b0, 1'(op));
      for (int i = 0; i < 20; i++) begin
        logic exp_q;
        @(negedge clk);
        pterm = (i == 0) ? 8'h80 : 8'($urandom);
        oe_n = 1'($urandom); pin_in = 1'($urandom);
        exp_q = |pterm;
        @(posedge clk);
        #1;
        pterm = ~pterm;
        #0.5;
        chk("R4", "pin_out after edge", pin_out, pol(exp_q, 1'(op)));
        chk("R4", "fb from register", fb, exp_q);
        chk("R4", "pin_oe", pin_oe, !oe_n);
      end
    end
  endtask

  task automatic t_unlisted();
    logic [1:0] gms [3] = '{2'b00, 2'b00, 2'b11};
    logic       rcs [3] = '{1'b0, 1'b1, 1'b0};
    for (int k = 0; k < 3; k++) begin
      setup(gms[k], rcs[k], 1'b1);
      for (int i = 0; i < 8; i++) begin
        drive_rand();
        chk("R7", "pin_oe", pin_oe, 1'b0);
        chk("R7", "fb", fb, pin_in);
      end
    end
  endtask

  task automatic t_ignored();
    logic o0, e0, f0;
    setup(2'b11, 1'b1, 1'b1);
    @(negedge clk); pterm = 8'h83; pin_in = 1'b1; oe_n = 1'b1; #1;
    o0 = pin_out; e0 = pin_oe; f0 = fb;
    oe_n = 1'b0;
    @(posedge clk); #1;
    chk("R8", "pin_out vs oe_n/clk", pin_out, o0);
    chk("R8", "pin_oe vs oe_n/clk", pin_oe, e0);
    chk("R8", "fb vs oe_n/clk", fb, f0);
    setup(2'b01, 1'b0, 1'b0);
    @(negedge clk); pterm = 8'h00; oe_n = 1'b1; #1;
    chk("R8", "simple oe ignores oe_n", pin_oe, 1'b1);
    chk("R8", "simple out ignores clk", pin_out, 1'b1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_simple_comb();
    t_simple_input();
    t_term_oe(2'b11, "R3");
    t_term_oe(2'b10, "R5");
    t_registered();
    t_unlisted();
    t_ignored();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule